// File: doc/BRIEF.md
# NAND Asynchronous Interface Sequencer

This block connects a simple request/acknowledge host port to an 8-bit asynchronous NAND flash device. Each host access to the flash port becomes one or more byte cycles on the device pins. Every byte cycle runs through four phases: setup, strobe, hold and a turnaround gap. The length of each phase comes from a packed timing word, and reads and writes have separate counts.

Two host address bits mark a byte cycle as a command cycle (CLE high) or an address cycle (ALE high). When both bits are clear, the cycle is a plain data transfer. Host accesses of 16 or 32 bits are split into consecutive byte cycles, lowest byte first. The timing word can be read and written through a register select bit. A second select bit returns the synchronised ready/busy pin as status.

Top module: `nand_async_seq`

## Requirements
- R1: After reset all strobes are idle: CE#, WE# and RE# are high, CLE, ALE, the data output enable and ack are low. The timing word reads back as 0x0432229C.
- R2: The timing word is selected by host_addr[3]. Its fields are: write setup [29:26], write strobe [25:20], write hold [19:17], read setup [16:13], read strobe [12:7], read hold [6:4], turnaround [3:2], bus size [0] (0 = 8-bit). Bits 31 and 30 are stored only. A write stores the new value, and the data returned on that write is the previous value.
- R3: Each byte cycle runs setup, strobe, hold and turnaround in that order. Each phase lasts its field value plus one clock, so a value of 0 gives a one-clock phase. Setup is the first clock after the request is accepted.
- R4: WE# is low only in the strobe phase of a write, and RE# only in the strobe phase of a read. CE# is low from the first setup clock through the last hold clock, and high during turnaround.
- R5: On a flash access, host_addr[1] raises CLE and host_addr[0] raises ALE, from setup through hold. Both stay low for data cycles and outside byte cycles.
- R6: host_size 0, 1 and 2 (or 3) give 1, 2 and 4 byte cycles. Byte k carries host_wdata[8k+7:8k]. The output enable is high from setup through hold of a write, and the data output is 0 otherwise.
- R7: Read data is sampled on the last clock of the read strobe phase. Byte k goes to host_rdata[8k+7:8k], and unused upper lanes return 0. A flash write returns 0.
- R8: ack is a one-clock pulse. It comes on the clock after the last byte's turnaround ends, or on the clock after acceptance for a register access. A request still held while ack is high does not start a new access.
- R9: host_addr[2] (when host_addr[3] is clear) reads status. Bit 0 is the ready pin (1 = ready) after a two-flop synchroniser, and the other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Access request, held until ack |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 4 | [3] timing word, [2] status, [1] CLE, [0] ALE |
| host_size | input | 2 | 0 byte, 1 half, 2/3 word |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid with ack |
| host_ack | output | 1 | Access complete pulse |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_dout | output | 8 | Data to device |
| nand_doe | output | 1 | Data output enable |
| nand_din | input | 8 | Data from device |
| nand_rdy | input | 1 | Ready/busy pin, 1 = ready |

## Verification
The assertions check pin relations on every cycle:
- the two strobes are never low together;
- WE#, CLE and ALE are only active while CE# is low;
- the output enable never overlaps RE#;
- ack is a single-clock pulse and only occurs with CE# high.

Phase lengths, byte order, the read sampling clock, default and programmed timings, and the held-request case depend on sequences. Only the bench's cycle-by-cycle reference model can show those.

// File: rtl/nand_async_seq.sv
module nand_async_seq #(
  parameter logic [31:0] CFG_RESET = 32'h0432_229C
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_req,
  input  logic        host_wr,
  input  logic [3:0]  host_addr,
  input  logic [1:0]  host_size,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        host_ack,
  output logic        nand_ce_n,
  output logic        nand_we_n,
  output logic        nand_re_n,
  output logic        nand_cle,
  output logic        nand_ale,
  output logic [7:0]  nand_dout,
  output logic        nand_doe,
  input  logic [7:0]  nand_din,
  input  logic        nand_rdy
);

  typedef enum logic [2:0] {IDLE, SETUP, STROBE, HOLD, TURN} st_t;

  st_t         st;
  logic [5:0]  cnt;
  logic [31:0] cfg, wbuf;
  logic        wr_q, cle_q, ale_q;
  logic [1:0]  idx, last_idx, rdy_s;

  logic [5:0] su_len, stb_len, ho_len, ta_len, acc_su;
  assign su_len  = wr_q ? {2'b0, cfg[29:26]} : {2'b0, cfg[16:13]};
  assign stb_len = wr_q ? cfg[25:20] : cfg[12:7];
  assign ho_len  = wr_q ? {3'b0, cfg[19:17]} : {3'b0, cfg[6:4]};
  assign ta_len  = {4'b0, cfg[3:2]};
  assign acc_su  = host_wr ? {2'b0, cfg[29:26]} : {2'b0, cfg[16:13]};

  logic in_cyc;
  assign in_cyc    = (st == SETUP) || (st == STROBE) || (st == HOLD);
  assign nand_ce_n = !in_cyc;
  assign nand_we_n = !(st == STROBE && wr_q);
  assign nand_re_n = !(st == STROBE && !wr_q);
  assign nand_cle  = in_cyc && cle_q;
  assign nand_ale  = in_cyc && ale_q;
  assign nand_doe  = in_cyc && wr_q;
  assign nand_dout = nand_doe ? wbuf[{idx, 3'b000} +: 8] : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE;  cnt <= '0;  cfg <= CFG_RESET;  wbuf <= '0;
      wr_q <= 1'b0;  cle_q <= 1'b0;  ale_q <= 1'b0;
      idx <= '0;  last_idx <= '0;  rdy_s <= '0;
      host_rdata <= '0;  host_ack <= 1'b0;
    end else begin
      rdy_s    <= {rdy_s[0], nand_rdy};
      host_ack <= 1'b0;
      case (st)
        IDLE: if (host_req && !host_ack) begin
          if (host_addr[3]) begin
            if (host_wr) cfg <= host_wdata;
            host_rdata <= cfg;
            host_ack   <= 1'b1;
          end else if (host_addr[2]) begin
            host_rdata <= {31'b0, rdy_s[1]};
            host_ack   <= 1'b1;
          end else begin
            wr_q <= host_wr;  cle_q <= host_addr[1];  ale_q <= host_addr[0];
            wbuf <= host_wdata;  host_rdata <= '0;  idx <= '0;
            last_idx <= (host_size == 2'd0) ? 2'd0 : (host_size == 2'd1) ? 2'd1 : 2'd3;
            cnt <= acc_su;
            st  <= SETUP;
          end
        end
        SETUP: if (cnt == 0) begin st <= STROBE; cnt <= stb_len; end
               else cnt <= cnt - 1'b1;
        STROBE: if (cnt == 0) begin
          if (!wr_q) host_rdata[{idx, 3'b000} +: 8] <= nand_din;
          st <= HOLD;  cnt <= ho_len;
        end else cnt <= cnt - 1'b1;
        HOLD: if (cnt == 0) begin st <= TURN; cnt <= ta_len; end
              else cnt <= cnt - 1'b1;
        TURN: if (cnt == 0) begin
          if (idx == last_idx) begin st <= IDLE; host_ack <= 1'b1; end
          else begin idx <= idx + 1'b1; st <= SETUP; cnt <= su_len; end
        end else cnt <= cnt - 1'b1;
        default: st <= IDLE;
      endcase
    end
  end

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));
  // R4
  we_in_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> !nand_ce_n);
  // R5
  latch_in_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nand_cle || nand_ale) |-> !nand_ce_n);
  // R6
  doe_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nand_doe |-> nand_re_n);
  // R8
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |=> !host_ack);
  // R8
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |-> nand_ce_n);

endmodule

// File: tb/nand_async_seq_tb.sv
module nand_async_seq_tb_top;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic host_req = 0, host_wr = 0;
  logic [3:0] host_addr = 0;
  logic [1:0] host_size = 0;
  logic [31:0] host_wdata = 0, host_rdata;
  logic host_ack, nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_doe;
  logic [7:0] nand_dout, nand_din = 0;
  logic nand_rdy = 1;

  always #(PERIOD/2) clk = ~clk;

  nand_async_seq dut_i (.clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
    .host_addr(host_addr), .host_size(host_size), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_ack(host_ack), .nand_ce_n(nand_ce_n),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_dout(nand_dout), .nand_doe(nand_doe), .nand_din(nand_din), .nand_rdy(nand_rdy));

  int checks = 0, fails = 0, cyc = 0;
  int ws = 1, wt = 3, wh = 1, rs = 1, rt = 5, rh = 1, ta = 3;
  logic [31:0] rd_pat = 32'h5E6F_7A8B;
  logic [16:0] q[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mk_cfg(int a, int b, int c, int d, int e, int f, int g, bit top);
    return ({31'b0, top} << 31) | (a << 26) | (b << 20) | (c << 17) | (d << 13) | (e << 7) | (f << 4) | (g << 2);
  endfunction

  // entry: [16:15] byte, [14] ack, [13] ce_n, [12] we_n, [11] re_n, [10] cle, [9] ale, [8] doe, [7:0] dout
  function automatic logic [16:0] ent(int b, bit ack, bit ce, bit we, bit re, bit cl, bit al, bit oe, logic [7:0] d);
    logic [1:0] bb = b[1:0];
    return {bb, ack, ce, we, re, cl, al, oe, d};
  endfunction

  task automatic check_ent(logic [16:0] e);
    chk("R8 ack", {31'b0, host_ack}, {31'b0, e[14]});
    chk("R3 ce_n", {31'b0, nand_ce_n}, {31'b0, e[13]});
    chk("R4 we_n", {31'b0, nand_we_n}, {31'b0, e[12]});
    chk("R4 re_n", {31'b0, nand_re_n}, {31'b0, e[11]});
    chk("R5 cle", {31'b0, nand_cle}, {31'b0, e[10]});
    chk("R5 ale", {31'b0, nand_ale}, {31'b0, e[9]});
    chk("R6 doe", {31'b0, nand_doe}, {31'b0, e[8]});
    chk("R6 dout", {24'b0, nand_dout}, {24'b0, e[7:0]});
  endtask

  task automatic nand_acc(bit wr, bit cl, bit al, logic [1:0] sz, logic [31:0] wd, bit hold_req);
    int nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    int su = wr ? ws : rs, sb = wr ? wt : rt, ho = wr ? wh : rh;
    logic [31:0] exp_rd = 0;
    q.delete();
    for (int b = 0; b < nb; b++) begin
      logic [7:0] d = wr ? wd[b*8 +: 8] : 8'h00;
      for (int i = 0; i <= su; i++) q.push_back(ent(b, 0, 0, 1, 1, cl, al, wr, d));
      for (int i = 0; i <= sb; i++) q.push_back(ent(b, 0, 0, !wr, wr, cl, al, wr, d));
      for (int i = 0; i <= ho; i++) q.push_back(ent(b, 0, 0, 1, 1, cl, al, wr, d));
      for (int i = 0; i <= ta; i++) q.push_back(ent(b, 0, 1, 1, 1, 0, 0, 0, 8'h00));
      if (!wr) exp_rd[b*8 +: 8] = rd_pat[b*8 +: 8];
    end
    q.push_back(ent(0, 1, 1, 1, 1, 0, 0, 0, 8'h00));
    nand_din = rd_pat[7:0];
    host_wr = wr; host_addr = {2'b00, cl, al}; host_size = sz; host_wdata = wd; host_req = 1;
    while (q.size() > 0) begin
      logic [16:0] e;
      @(negedge clk);
      e = q.pop_front();
      check_ent(e);
      if (e[14]) begin
        chk("R7 rdata", host_rdata, exp_rd);
        if (!hold_req) host_req = 0;
      end
      if (q.size() > 0) nand_din = rd_pat[{q[0][16:15], 3'b000} +: 8];
    end
    if (hold_req) begin
      @(negedge clk);
      chk("R8 held req no restart ce_n", {31'b0, nand_ce_n}, 32'd1);
      chk("R8 ack low after pulse", {31'b0, host_ack}, 32'd0);
      host_req = 0;
    end
    @(negedge clk);
    chk("R8 idle after access", {31'b0, nand_ce_n}, 32'd1);
  endtask

  task automatic reg_acc(bit wr, logic [3:0] a, logic [31:0] wd, logic [31:0] exp, string tag);
    host_wr = wr; host_addr = a; host_wdata = wd; host_size = 2; host_req = 1;
    @(negedge clk);
    chk({tag, " ack"}, {31'b0, host_ack}, 32'd1);
    chk({tag, " data"}, host_rdata, exp);
    chk({tag, " no flash cycle"}, {31'b0, nand_ce_n}, 32'd1);
    host_req = 0;
    @(negedge clk);
    chk("R8 register ack pulse", {31'b0, host_ack}, 32'd0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      fails++;
      $display("FAIL R8 watchdog act=hung exp=ack");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ce_n", {31'b0, nand_ce_n}, 32'd1);
    chk("R1 we_n", {31'b0, nand_we_n}, 32'd1);
    chk("R1 re_n", {31'b0, nand_re_n}, 32'd1);
    chk("R1 cle", {31'b0, nand_cle}, 32'd0);
    chk("R1 ale", {31'b0, nand_ale}, 32'd0);
    chk("R1 doe", {31'b0, nand_doe}, 32'd0);
    chk("R1 ack", {31'b0, host_ack}, 32'd0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    reg_acc(0, 4'b1000, 0, 32'h0432_229C, "R1 default timing");
    chk("R2 default field encode", mk_cfg(1, 3, 1, 1, 5, 1, 3, 0), 32'h0432_229C);
    // R9 status
    reg_acc(0, 4'b0100, 0, 32'd1, "R9 ready");
    nand_rdy = 0;
    repeat (3) @(negedge clk);
    reg_acc(0, 4'b0100, 0, 32'd0, "R9 busy");
    nand_rdy = 1;
    // R5 command, address; R3 R4 default timings
    nand_acc(1, 1, 0, 0, 32'h0000_0090, 0);
    nand_acc(1, 0, 1, 0, 32'h0000_0012, 0);
    // R6 multi-byte writes
    nand_acc(1, 0, 0, 2, 32'hA1B2_C3D4, 0);
    nand_acc(1, 0, 0, 1, 32'h0000_BEEF, 0);
    // R7 reads of each size
    nand_acc(0, 0, 0, 0, 0, 0);
    nand_acc(0, 0, 0, 1, 0, 0);
    rd_pat = 32'hC0DE_1357;
    nand_acc(0, 0, 0, 2, 0, 0);
    // R2 reprogram with zero and odd values; write returns old value
    reg_acc(1, 4'b1000, mk_cfg(0, 0, 0, 2, 1, 0, 0, 1), 32'h0432_229C, "R2 write old");
    reg_acc(0, 4'b1000, 0, mk_cfg(0, 0, 0, 2, 1, 0, 0, 1), "R2 readback");
    ws = 0; wt = 0; wh = 0; rs = 2; rt = 1; rh = 0; ta = 0;
    // R3 one-clock phases
    nand_acc(1, 0, 0, 2, 32'h1122_3344, 0);
    nand_acc(0, 1, 1, 2, 0, 0);
    // R8 request held through ack
    nand_acc(1, 0, 0, 1, 32'h0000_7788, 1);
    finish_run();
  end
endmodule